// File: doc/BRIEF.md
# Crossbar Global Lock Controller

This block decides which master, if any, owns a multi-master, multi-slave crossbar for an atomic sequence. It has no data path. It watches, for each master, a lock request, a flag that marks a transfer the crossbar has already granted (address or data phase), a flag that marks a burst continuation, and a flag that marks a new transfer being presented. It also watches the shared bus ready. From these it drives three things: a per-master stall that the crossbar folds into that master's ready, a per-master grant-allowed mask that gates the crossbar's request logic, and one lock qualifier sent to every slave.

A lock request never takes the bus at once. The controller first records the winning requester as owner and enters a drain phase. In that phase no master may start a new address phase, but transfers already in flight and bursts already under way run to completion. Once no other master has anything outstanding, the owner holds the whole crossbar until it drops its request. Release is sampled together with bus ready, so the final locked data phase still completes under the lock qualifier.

Top module: `xbar_lock_ctrl`

## Requirements
- R1: After reset the controller is idle with no owner: `slave_lock` is 0, no `stall` bit is set, and with no lock request every `grant_ok` bit is 1.
- R2: While idle, `grant_ok[m]` equals the inverse of `lock_req[m]` and `stall[m]` equals `lock_req[m] & xfer_valid[m]`. Any lock request moves the controller to the drain phase on the next clock edge.
- R3: When several masters request the lock in the same idle cycle, the owner is the one with the lowest index.
- R4: During drain every `grant_ok` bit is 0. The owner is stalled whenever `xfer_valid` is set. A non-owner is stalled only when it presents `xfer_valid` with neither `in_flight` nor `mid_burst` set.
- R5: Drain becomes locked at the first clock edge at which no non-owner has `in_flight` or `mid_burst` set. A burst continuation therefore delays the lock just as a granted transfer does.
- R6: If the owner drops `lock_req` during drain, the controller returns to idle with no owner at the next edge and never asserts `slave_lock`.
- R7: While locked, `slave_lock` is 1, `grant_ok` has only the owner's bit set, and the owner is never stalled. A non-owner is stalled when it presents `xfer_valid` with neither `in_flight` nor `mid_burst` set.
- R8: The lock ends at a clock edge at which the owner's `lock_req` is 0 and `bus_ready` is 1, and the controller is idle in the following cycle. With `bus_ready` at 0 the lock is kept.
- R9: At most one master is ever owner. While locked with the owner's request held, the owner does not change.
- R10: A master that requested the lock and lost stays stalled for the whole time the lock is held. After release it is picked as the next owner, in index order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_req | input | N_MASTERS | Per-master request for exclusive ownership |
| in_flight | input | N_MASTERS | Per-master flag: a granted address or data phase is outstanding |
| mid_burst | input | N_MASTERS | Per-master flag: master is continuing a burst (BUSY or SEQ) |
| xfer_valid | input | N_MASTERS | Per-master flag: master presents a transfer this cycle |
| bus_ready | input | 1 | Shared bus ready |
| stall | output | N_MASTERS | Per-master ready suppression |
| grant_ok | output | N_MASTERS | Per-master permission to be granted a slave |
| slave_lock | output | 1 | Global lock qualifier for all slaves |

## Verification
Random traffic keeps lock requests sticky and scatters in-flight, burst and valid flags, so that drain phases of varying length occur. This separates a controller that waits for every other master to empty from one that locks early. Directed sequences cover four cases. A lone requester on a quiet bus shows the minimum latency through drain. A burst-only neighbour shows that burst continuation blocks the lock. Simultaneous requesters show the index priority and the hand-over after release. Release with bus ready held low shows that the lock is kept until the final data phase is accepted.

// File: rtl/xbar_lock_pkg.sv
package xbar_lock_pkg;
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_DRAIN = 2'd1,
    LK_HELD  = 2'd2
  } lock_state_e;
endpackage

// File: rtl/xbar_lock_pick.sv
module xbar_lock_pick #(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req,
  output logic [N_MASTERS-1:0] win,
  output logic                 any
);
  function automatic logic [N_MASTERS-1:0] first_set(input logic [N_MASTERS-1:0] v);
    logic [N_MASTERS-1:0] r;
    logic                 seen;
    r    = '0;
    seen = 1'b0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (v[i] && !seen) begin
        r[i] = 1'b1;
        seen = 1'b1;
      end
    end
    return r;
  endfunction

  assign win = first_set(req);
  assign any = |req;
endmodule

// File: rtl/xbar_lock_fsm.sv
module xbar_lock_fsm
  import xbar_lock_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] lock_req,
  input  logic [N_MASTERS-1:0] busy_vec,
  input  logic                 bus_ready,
  input  logic [N_MASTERS-1:0] pick_win,
  input  logic                 pick_any,
  output lock_state_e          state,
  output logic [N_MASTERS-1:0] owner_q,
  output logic                 others_busy,
  output logic                 owner_req
);
  lock_state_e          st_q, st_d;
  logic [N_MASTERS-1:0] own_d;

  function automatic logic masked_any(input logic [N_MASTERS-1:0] v,
                                      input logic [N_MASTERS-1:0] m);
    return |(v & m);
  endfunction

  assign others_busy = masked_any(busy_vec, ~owner_q);
  assign owner_req   = masked_any(lock_req, owner_q);

  always_comb begin
    st_d  = st_q;
    own_d = owner_q;
    unique case (st_q)
      LK_IDLE: begin
        if (pick_any) begin
          st_d  = LK_DRAIN;
          own_d = pick_win;
        end
      end
      LK_DRAIN: begin
        if (!owner_req) begin
          st_d  = LK_IDLE;
          own_d = '0;
        end else if (!others_busy) begin
          st_d = LK_HELD;
        end
      end
      LK_HELD: begin
        if (!owner_req && bus_ready) begin
          st_d  = LK_IDLE;
          own_d = '0;
        end
      end
      default: begin
        st_d  = LK_IDLE;
        own_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      owner_q <= '0;
    end else begin
      st_q    <= st_d;
      owner_q <= own_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/xbar_lock_gate.sv
module xbar_lock_gate
  import xbar_lock_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  lock_state_e          state,
  input  logic [N_MASTERS-1:0] owner_q,
  input  logic [N_MASTERS-1:0] lock_req,
  input  logic [N_MASTERS-1:0] xfer_valid,
  input  logic [N_MASTERS-1:0] busy_vec,
  output logic [N_MASTERS-1:0] stall,
  output logic [N_MASTERS-1:0] grant_ok,
  output logic                 slave_lock
);
  logic is_idle, is_drain, is_held;

  assign is_idle    = (state == LK_IDLE);
  assign is_drain   = (state == LK_DRAIN);
  assign is_held    = (state == LK_HELD);
  assign slave_lock = is_held;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_master
    logic fresh;
    assign fresh = xfer_valid[m] & ~busy_vec[m];
    always_comb begin
      if (is_idle) begin
        stall[m]    = lock_req[m] & xfer_valid[m];
        grant_ok[m] = ~lock_req[m];
      end else if (owner_q[m]) begin
        stall[m]    = is_drain & xfer_valid[m];
        grant_ok[m] = is_held;
      end else begin
        stall[m]    = fresh;
        grant_ok[m] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xbar_lock_ctrl.sv
module xbar_lock_ctrl
  import xbar_lock_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] lock_req,
  input  logic [N_MASTERS-1:0] in_flight,
  input  logic [N_MASTERS-1:0] mid_burst,
  input  logic [N_MASTERS-1:0] xfer_valid,
  input  logic                 bus_ready,
  output logic [N_MASTERS-1:0] stall,
  output logic [N_MASTERS-1:0] grant_ok,
  output logic                 slave_lock
);
  logic [N_MASTERS-1:0] busy_vec;
  logic [N_MASTERS-1:0] pick_win;
  logic                 pick_any;
  lock_state_e          state;
  logic [N_MASTERS-1:0] owner_q;
  logic                 others_busy;
  logic                 owner_req;

  assign busy_vec = in_flight | mid_burst;

  xbar_lock_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req (lock_req),
    .win (pick_win),
    .any (pick_any)
  );

  xbar_lock_fsm #(.N_MASTERS(N_MASTERS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_req    (lock_req),
    .busy_vec    (busy_vec),
    .bus_ready   (bus_ready),
    .pick_win    (pick_win),
    .pick_any    (pick_any),
    .state       (state),
    .owner_q     (owner_q),
    .others_busy (others_busy),
    .owner_req   (owner_req)
  );

  xbar_lock_gate #(.N_MASTERS(N_MASTERS)) u_gate (
    .state      (state),
    .owner_q    (owner_q),
    .lock_req   (lock_req),
    .xfer_valid (xfer_valid),
    .busy_vec   (busy_vec),
    .stall      (stall),
    .grant_ok   (grant_ok),
    .slave_lock (slave_lock)
  );
endmodule

// File: rtl/xbar_lock_chk.sv
module xbar_lock_chk
  import xbar_lock_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input lock_state_e          state,
  input logic [N_MASTERS-1:0] owner_q,
  input logic                 others_busy,
  input logic                 owner_req,
  input logic                 bus_ready,
  input logic [N_MASTERS-1:0] grant_ok,
  input logic [N_MASTERS-1:0] stall,
  input logic                 slave_lock
);
  // R9
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_q));

  // R7
  held_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_HELD) |-> ((grant_ok & ~owner_q) == '0));

  // R7
  owner_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_HELD) |-> ((stall & owner_q) == '0));

  // R4
  drain_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_DRAIN) |-> (grant_ok == '0));

  // R5
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_lock) |-> ($past(state) == LK_DRAIN && !$past(others_busy)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_HELD && !owner_req && bus_ready) |=> (state == LK_IDLE && !slave_lock));

  // R9
  owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_HELD && owner_req) |=> (state == LK_HELD && $stable(owner_q)));
endmodule

bind xbar_lock_ctrl xbar_lock_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (state),
  .owner_q     (owner_q),
  .others_busy (others_busy),
  .owner_req   (owner_req),
  .bus_ready   (bus_ready),
  .grant_ok    (grant_ok),
  .stall       (stall),
  .slave_lock  (slave_lock)
);

// File: tb/xbar_lock_ctrl_bench.sv
module xbar_lock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] lock_req = '0, in_flight = '0, mid_burst = '0, xfer_valid = '0;
  logic          bus_ready = 1'b1;
  logic [NM-1:0] stall, grant_ok;
  logic          slave_lock;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: 0 idle, 1 drain, 2 locked
  int          m_st = 0;
  int          m_own = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_lock_ctrl #(.N_MASTERS(NM)) u_xbar_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .in_flight(in_flight),
    .mid_burst(mid_burst), .xfer_valid(xfer_valid), .bus_ready(bus_ready),
    .stall(stall), .grant_ok(grant_ok), .slave_lock(slave_lock)
  );

  function automatic logic [NM-1:0] want_stall(int st, int own);
    logic [NM-1:0] r;
    for (int m = 0; m < NM; m++) begin
      logic busy;
      busy = in_flight[m] | mid_burst[m];
      if (st == 0)        r[m] = lock_req[m] && xfer_valid[m];
      else if (m == own)  r[m] = (st == 1) ? xfer_valid[m] : 1'b0;
      else                r[m] = xfer_valid[m] && !busy;
    end
    return r;
  endfunction

  function automatic logic [NM-1:0] want_grant(int st, int own);
    logic [NM-1:0] r;
    for (int m = 0; m < NM; m++) begin
      if (st == 0)      r[m] = !lock_req[m];
      else if (st == 2) r[m] = (m == own);
      else              r[m] = 1'b0;
    end
    return r;
  endfunction

  task automatic cmp(string tag, logic [NM-1:0] act, logic [NM-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int st);
    if (st == 0) return "R2";
    if (st == 1) return "R4";
    return "R7";
  endfunction

  task automatic check_now();
    cmp(tag_of(m_st), stall, want_stall(m_st, m_own));
    cmp(tag_of(m_st), grant_ok, want_grant(m_st, m_own));
    // R5 R6 R8: lock qualifier follows the model state
    cmp("R5/R6/R8 lock", {{(NM-1){1'b0}}, slave_lock}, {{(NM-1){1'b0}}, m_st == 2});
  endtask

  task automatic advance_model();
    logic others;
    others = 1'b0;
    for (int m = 0; m < NM; m++)
      if (m != m_own && (in_flight[m] | mid_burst[m])) others = 1'b1;
    case (m_st)
      0: begin
        // R3: lowest index requester wins
        for (int m = NM-1; m >= 0; m--) if (lock_req[m]) begin m_st = 1; m_own = m; end
      end
      1: begin
        if (!lock_req[m_own]) begin m_st = 0; m_own = -1; end
        else if (!others) m_st = 2;
      end
      default: begin
        if (!lock_req[m_own] && bus_ready) begin m_st = 0; m_own = -1; end
      end
    endcase
  endtask

  task automatic step(logic [NM-1:0] lr, logic [NM-1:0] inf, logic [NM-1:0] mb,
                      logic [NM-1:0] xv, logic rdy);
    @(negedge clk);
    lock_req = lr; in_flight = inf; mid_burst = mb; xfer_valid = xv; bus_ready = rdy;
    #1;
    check_now();
    @(posedge clk);
    advance_model();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NM-1:0] lr;
    void'($urandom(32'h1ced_5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cmp("R1 stall", stall, '0);
    cmp("R1 grant", grant_ok, '1);
    cmp("R1 lock", {{(NM-1){1'b0}}, slave_lock}, '0);
    rst_n = 1'b1;
    @(posedge clk);

    // R2 R5: lone requester, quiet bus -> drain one cycle, then locked
    step(4'b0100, 4'b0000, 4'b0000, 4'b0100, 1'b1);
    step(4'b0100, 4'b0000, 4'b0000, 4'b0100, 1'b1);
    step(4'b0100, 4'b0000, 4'b0000, 4'b0101, 1'b1);
    // R8: release with ready low keeps lock, ready high drops it
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);

    // R5: burst continuation of master 0 delays lock of master 1
    step(4'b0010, 4'b0000, 4'b0001, 4'b0011, 1'b1);
    step(4'b0010, 4'b0000, 4'b0001, 4'b0011, 1'b1);
    step(4'b0010, 4'b0000, 4'b0001, 4'b0011, 1'b1);
    step(4'b0010, 4'b0000, 4'b0000, 4'b0011, 1'b1);
    step(4'b0010, 4'b0000, 4'b0000, 4'b0011, 1'b1);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);

    // R6: abort during drain
    step(4'b1000, 4'b0001, 4'b0000, 4'b1000, 1'b1);
    step(4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b1);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);

    // R3 R10: simultaneous requesters, hand-over in index order
    step(4'b1110, 4'b0000, 4'b0000, 4'b1110, 1'b1);
    step(4'b1110, 4'b0000, 4'b0000, 4'b1110, 1'b1);
    step(4'b1110, 4'b0000, 4'b0000, 4'b1110, 1'b1);
    step(4'b1100, 4'b0000, 4'b0000, 4'b1100, 1'b1);
    step(4'b1100, 4'b0000, 4'b0000, 4'b1100, 1'b1);
    step(4'b1100, 4'b0000, 4'b0000, 4'b1100, 1'b1);
    step(4'b1000, 4'b0000, 4'b0000, 4'b1000, 1'b1);
    step(4'b1000, 4'b0000, 4'b0000, 4'b1000, 1'b1);
    step(4'b1000, 4'b0000, 4'b0000, 4'b1000, 1'b1);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);

    // R9 R4 R7: constrained random traffic, sticky lock requests
    lr = '0;
    for (int c = 0; c < 4000; c++) begin
      logic [NM-1:0] inf, mb, xv;
      for (int m = 0; m < NM; m++) begin
        if ($urandom % 10 == 0) lr[m] = ~lr[m];
        inf[m] = ($urandom % 4 == 0);
        mb[m]  = ($urandom % 8 == 0);
        xv[m]  = ($urandom % 2 == 0);
      end
      step(lr, inf, mb, xv, ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule